// File: doc/BRIEF.md
# Port-I/O Space Decoder with Configuration-Address Latch

This block turns a request aimed at the internal port-I/O address space into a physical request. It splits the request address into a space code and a port number. It then classifies the port and builds a physical address, together with an uncacheable flag and an internal-register flag. Addresses that cannot be decoded raise an error output.

The block keeps one 32-bit configuration-address register. A 4-byte access to port 0xCF8 targets this register, and a 4-byte write loads it. Bit 31 of the register acts as an enable. While the enable is set, accesses to the four data ports 0xCFC..0xCFF are steered into configuration space, and register bits 30:2 select the location there. While the enable is clear, those ports behave like any other I/O port.

The decode is combinational, so the outputs follow the request in the same cycle. Only the register is clocked.

Top module: `pio_cfg_decoder`

## Requirements
- R1: A synchronous reset (rst_n low at a rising edge) clears the configuration-address register. After reset, a data-port access therefore decodes as plain I/O (R7 form).
- R2: If the space code vaddr[63:35] is not 2, rsp_error is 1. In that case rsp_paddr is 0, and rsp_uncacheable and rsp_int_reg are both 0.
- R3: With space code 2, a port field vaddr[34:3] that has any of bits 31:16 set gives rsp_error=1, with the other outputs zero.
- R4: A 4-byte access (req_size=4) to port 0xCF8 gives rsp_int_reg=1, rsp_uncacheable=0 and rsp_paddr=0x200 (register slot 0x40 times 8).
- R5: A valid write of size 4 to port 0xCF8 loads req_wdata into the register at the next rising edge. A read, a write of any other size, or an erroneous request leaves the register unchanged.
- R6: When register bit 31 is 1, an access to port 0xCFC..0xCFF gives rsp_paddr = 0xC000_0000_0000_0000 | (reg & 0x7FFF_FFFC) | port[1:0], with rsp_uncacheable=1.
- R7: When register bit 31 is 0, an access to port 0xCFC..0xCFF gives rsp_paddr = 0x8000_0000_0000_0000 | port, with rsp_uncacheable=1.
- R8: Any other port gives rsp_paddr = 0x8000_0000_0000_0000 | port, with rsp_uncacheable=1 and rsp_int_reg=0. This includes port 0xCF8 accessed with a size other than 4.
- R9: With req_valid low, all four response outputs are 0.
- R10: rsp_int_reg and rsp_uncacheable are never 1 together, and rsp_error excludes both of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | Request is a write |
| req_size | input | 4 | Access size in bytes |
| req_vaddr | input | 64 | Internal-space address: space code [63:35], port [34:3] |
| req_wdata | input | 32 | Write data, used for the configuration-address register |
| rsp_paddr | output | 64 | Decoded physical address |
| rsp_uncacheable | output | 1 | Access must bypass caches |
| rsp_int_reg | output | 1 | Access targets the internal configuration-address register |
| rsp_error | output | 1 | Address could not be decoded |

## Verification
Some properties are checked by assertions on every cycle. These are the silence of the outputs without a request, the mutual exclusion of the flags, and the zeroed outputs on error. The assertions also check that the register hit on 0xCF8 is always flagged, that data-window accesses are always uncacheable, and that the register only changes after a qualifying write. The exact address values need the bench's scenarios, which pair a write to 0xCF8 with later data-port accesses: the enable-gated steering into configuration space, the field placement from register bits 30:2, and the register being cleared by reset.

// File: rtl/pio_cfg_pkg.sv
// Package: shared types and default encodings for the port-I/O decoder.
// Assumes a 64-bit internal address with a 3-bit zero-weight low field.
package pio_cfg_pkg;

    // Classification of one request
    typedef enum logic [2:0] {
        PK_NONE     = 3'd0,
        PK_ERROR    = 3'd1,
        PK_CFG_REG  = 3'd2,
        PK_DATA_WIN = 3'd3,
        PK_PLAIN    = 3'd4
    } pio_kind_e;

    localparam logic [63:0] DEF_IO_SPACE_CODE = 64'd2;
    localparam logic [63:0] DEF_IO_PREFIX     = 64'h8000_0000_0000_0000;
    localparam logic [63:0] DEF_CFG_PREFIX    = 64'hC000_0000_0000_0000;
    localparam int unsigned DEF_CFG_SLOT      = 32'h40;
    localparam logic [15:0] CFG_ADDR_PORT     = 16'h0CF8;
    localparam logic [15:0] CFG_DATA_BASE     = 16'h0CFC;

endpackage

// File: rtl/pio_space_decode.sv
// Module: pio_space_decode
// Splits the request address into space code and port, and classifies it.
// Assumes the port field sits directly above a 3-bit low field.
module pio_space_decode
    import pio_cfg_pkg::*;
#(
    parameter int unsigned VA_W          = 64,
    parameter int unsigned PORT_FIELD_W  = 32,
    parameter logic [63:0] IO_SPACE_CODE = DEF_IO_SPACE_CODE
) (
    input  logic            req_valid,
    input  logic [3:0]      req_size,
    input  logic [VA_W-1:0] req_vaddr,
    output pio_kind_e       kind,
    output logic [15:0]     port
);
    localparam int unsigned PFX_LO = 3 + PORT_FIELD_W;
    localparam int unsigned PFX_W  = VA_W - PFX_LO;
    localparam logic [PFX_W-1:0] IO_CODE = IO_SPACE_CODE[PFX_W-1:0];

    logic [PFX_W-1:0]        space_code;
    logic [PORT_FIELD_W-1:0] port_field;
    logic                    port_fits;

    // Field extraction
    assign space_code = req_vaddr[VA_W-1:PFX_LO];
    assign port_field = req_vaddr[PFX_LO-1:3];
    assign port       = port_field[15:0];

    // Port must fit in 16 bits
    generate
        if (PORT_FIELD_W > 16) begin : g_range
            assign port_fits = (port_field[PORT_FIELD_W-1:16] == '0);
        end else begin : g_narrow
            assign port_fits = 1'b1;
        end
    endgenerate

    // Classification
    always_comb begin
        if (!req_valid) begin
            kind = PK_NONE;
        end else if (space_code != IO_CODE || !port_fits) begin
            kind = PK_ERROR;
        end else if (port == CFG_ADDR_PORT && req_size == 4'd4) begin
            kind = PK_CFG_REG;
        end else if (port[15:2] == CFG_DATA_BASE[15:2]) begin
            kind = PK_DATA_WIN;
        end else begin
            kind = PK_PLAIN;
        end
    end

endmodule

// File: rtl/pio_cfg_latch.sv
// Module: pio_cfg_latch
// Holds the 32-bit configuration-address register.
// Assumes commit is already qualified; reset is synchronous, active low.
module pio_cfg_latch #(
    parameter int unsigned REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] cfg_q
);
    // Register load or clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (commit) begin
            cfg_q <= wdata;
        end
    end

endmodule

// File: rtl/pio_addr_compose.sv
// Module: pio_addr_compose
// Builds the physical address and the flags from the classification.
// Assumes bit 31 of the register is the enable and bits 30:2 are the offset.
module pio_addr_compose
    import pio_cfg_pkg::*;
#(
    parameter int unsigned PA_W       = 64,
    parameter logic [63:0] IO_PREFIX  = DEF_IO_PREFIX,
    parameter logic [63:0] CFG_PREFIX = DEF_CFG_PREFIX,
    parameter int unsigned CFG_SLOT   = DEF_CFG_SLOT
) (
    input  pio_kind_e       kind,
    input  logic [15:0]     port,
    input  logic [31:0]     cfg_q,
    output logic [PA_W-1:0] paddr,
    output logic            uncacheable,
    output logic            int_reg,
    output logic            error
);
    localparam logic [PA_W-1:0] IO_PFX   = IO_PREFIX[PA_W-1:0];
    localparam logic [PA_W-1:0] CFG_PFX  = CFG_PREFIX[PA_W-1:0];
    localparam logic [PA_W-1:0] REG_ADDR = PA_W'(CFG_SLOT) << 3;

    logic [PA_W-1:0] io_addr;
    logic [PA_W-1:0] cfg_addr;

    // Candidate addresses
    assign io_addr  = IO_PFX | PA_W'(port);
    assign cfg_addr = CFG_PFX | PA_W'({1'b0, cfg_q[30:2], port[1:0]});

    // Output selection
    always_comb begin
        paddr       = '0;
        uncacheable = 1'b0;
        int_reg     = 1'b0;
        error       = 1'b0;
        case (kind)
            PK_ERROR:    error = 1'b1;
            PK_CFG_REG: begin
                int_reg = 1'b1;
                paddr   = REG_ADDR;
            end
            PK_DATA_WIN: begin
                uncacheable = 1'b1;
                paddr       = cfg_q[31] ? cfg_addr : io_addr;
            end
            PK_PLAIN: begin
                uncacheable = 1'b1;
                paddr       = io_addr;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/pio_cfg_decoder.sv
// Module: pio_cfg_decoder (top)
// Decodes port-I/O requests and keeps the configuration-address register.
// Assumes one request per cycle; outputs are combinational in the request.
module pio_cfg_decoder
    import pio_cfg_pkg::*;
#(
    parameter int unsigned VA_W          = 64,
    parameter int unsigned PA_W          = 64,
    parameter int unsigned PORT_FIELD_W  = 32,
    parameter logic [63:0] IO_SPACE_CODE = DEF_IO_SPACE_CODE,
    parameter logic [63:0] IO_PREFIX     = DEF_IO_PREFIX,
    parameter logic [63:0] CFG_PREFIX    = DEF_CFG_PREFIX,
    parameter int unsigned CFG_SLOT      = DEF_CFG_SLOT
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic            req_write,
    input  logic [3:0]      req_size,
    input  logic [VA_W-1:0] req_vaddr,
    input  logic [31:0]     req_wdata,
    output logic [PA_W-1:0] rsp_paddr,
    output logic            rsp_uncacheable,
    output logic            rsp_int_reg,
    output logic            rsp_error
);
    pio_kind_e   kind;
    logic [15:0] port;
    logic [31:0] cfg_q;
    logic        cfg_commit;

    pio_space_decode #(
        .VA_W(VA_W), .PORT_FIELD_W(PORT_FIELD_W), .IO_SPACE_CODE(IO_SPACE_CODE)
    ) u_decode (
        .req_valid(req_valid), .req_size(req_size), .req_vaddr(req_vaddr),
        .kind(kind), .port(port)
    );

    // Write qualification for the register
    assign cfg_commit = req_write && (kind == PK_CFG_REG);

    pio_cfg_latch #(.REG_W(32)) u_latch (
        .clk(clk), .rst_n(rst_n), .commit(cfg_commit),
        .wdata(req_wdata), .cfg_q(cfg_q)
    );

    pio_addr_compose #(
        .PA_W(PA_W), .IO_PREFIX(IO_PREFIX), .CFG_PREFIX(CFG_PREFIX), .CFG_SLOT(CFG_SLOT)
    ) u_compose (
        .kind(kind), .port(port), .cfg_q(cfg_q),
        .paddr(rsp_paddr), .uncacheable(rsp_uncacheable),
        .int_reg(rsp_int_reg), .error(rsp_error)
    );

endmodule

// File: rtl/pio_cfg_decoder_chk.sv
// Module: pio_cfg_decoder_chk
// Cycle-by-cycle properties of the decoder, bound to the top module.
module pio_cfg_decoder_chk #(
    parameter int unsigned VA_W = 64,
    parameter int unsigned PA_W = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_write,
    input logic [3:0]      req_size,
    input logic [VA_W-1:0] req_vaddr,
    input logic [PA_W-1:0] rsp_paddr,
    input logic            rsp_uncacheable,
    input logic            rsp_int_reg,
    input logic            rsp_error,
    input logic [31:0]     cfg_q
);
    logic        io_ok;
    logic [31:0] prt;

    assign io_ok = (req_vaddr[VA_W-1:35] == 29'd2) && (req_vaddr[34:19] == 16'd0);
    assign prt   = req_vaddr[34:3];

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (rsp_paddr == '0 && !rsp_uncacheable && !rsp_int_reg && !rsp_error)); // R9
    AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_int_reg && rsp_uncacheable)); // R10
    AST_ERR_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_error |-> (rsp_paddr == '0 && !rsp_uncacheable && !rsp_int_reg)); // R2
    AST_CFGREG_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && io_ok && prt == 32'h0CF8 && req_size == 4'd4) |-> (rsp_int_reg && rsp_paddr == 64'h200)); // R4
    AST_WIN_UNCACHED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && io_ok && prt[15:2] == 14'h033F) |-> rsp_uncacheable); // R7
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_write && io_ok && prt == 32'h0CF8 && req_size == 4'd4) |=> $stable(cfg_q)); // R5

endmodule

bind pio_cfg_decoder pio_cfg_decoder_chk #(.VA_W(VA_W), .PA_W(PA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_vaddr(req_vaddr), .rsp_paddr(rsp_paddr),
    .rsp_uncacheable(rsp_uncacheable), .rsp_int_reg(rsp_int_reg),
    .rsp_error(rsp_error), .cfg_q(cfg_q)
);

// File: tb/test_pio_cfg_decoder.sv
module test_pio_cfg_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [3:0]  req_size = 4'd0;
    logic [63:0] req_vaddr = 64'd0;
    logic [31:0] req_wdata = 32'd0;
    logic [63:0] rsp_paddr;
    logic        rsp_uncacheable, rsp_int_reg, rsp_error;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    logic [31:0] shadow = 32'd0;

    always #5 clk = ~clk;

    pio_cfg_decoder i_pio_cfg_decoder (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_vaddr(req_vaddr), .req_wdata(req_wdata),
        .rsp_paddr(rsp_paddr), .rsp_uncacheable(rsp_uncacheable),
        .rsp_int_reg(rsp_int_reg), .rsp_error(rsp_error)
    );

    function automatic logic [63:0] mkva(input logic [28:0] code, input logic [31:0] prt);
        return {code, prt, 3'b000};
    endfunction

    // Expected response from the requirements
    function automatic void model(input logic v, input logic [3:0] sz, input logic [63:0] va,
                                  input logic [31:0] cfg, output logic [63:0] pa,
                                  output logic uc, output logic ir, output logic er,
                                  output string tag);
        logic [31:0] prt;
        prt = va[34:3];
        pa = 64'd0; uc = 1'b0; ir = 1'b0; er = 1'b0;
        if (!v) tag = "R9";
        else if (va[63:35] != 29'd2) begin er = 1'b1; tag = "R2"; end
        else if (prt[31:16] != 16'd0) begin er = 1'b1; tag = "R3"; end
        else if (prt == 32'h0CF8 && sz == 4'd4) begin ir = 1'b1; pa = 64'h200; tag = "R4"; end
        else if (prt[15:2] == 14'h033F) begin
            uc = 1'b1;
            if (cfg[31]) begin
                pa = 64'hC000_0000_0000_0000 | {32'd0, cfg & 32'h7FFF_FFFC} | {62'd0, prt[1:0]};
                tag = "R6";
            end else begin
                pa = 64'h8000_0000_0000_0000 | {32'd0, prt};
                tag = "R7";
            end
        end else begin
            uc = 1'b1; pa = 64'h8000_0000_0000_0000 | {32'd0, prt}; tag = "R8";
        end
    endfunction

    task automatic apply(input logic v, input logic w, input logic [3:0] sz,
                         input logic [63:0] va, input logic [31:0] wd, input string note);
        logic [63:0] pa;
        logic uc, ir, er;
        string tag;
        @(negedge clk);
        req_valid = v; req_write = w; req_size = sz; req_vaddr = va; req_wdata = wd;
        #1;
        model(v, sz, va, shadow, pa, uc, ir, er, tag);
        n_chk++;
        if (rsp_paddr !== pa || rsp_uncacheable !== uc || rsp_int_reg !== ir || rsp_error !== er) begin
            n_bad++;
            $display("FAIL %s %s: got pa=%h uc=%b ir=%b er=%b exp pa=%h uc=%b ir=%b er=%b",
                     tag, note, rsp_paddr, rsp_uncacheable, rsp_int_reg, rsp_error, pa, uc, ir, er);
        end
        // R5: register loads at the coming edge
        if (v && w && tag == "R4") shadow = wd;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1 reset state: data port decodes as plain I/O
        apply(1, 0, 4'd4, mkva(29'd2, 32'h0CFC), 0, "R1 after reset");
        apply(0, 0, 4'd4, mkva(29'd2, 32'h0CF8), 0, "R9 idle");
        apply(1, 0, 4'd4, mkva(29'd5, 32'h0CF8), 0, "R2 bad space");
        apply(1, 1, 4'd4, mkva(29'd2, 32'h0001_0CF8), 32'h8000_0000, "R3 wide port");
        apply(1, 1, 4'd2, mkva(29'd2, 32'h0CF8), 32'h8000_1234, "R8 short write to 0xCF8");
        apply(1, 0, 4'd1, mkva(29'd2, 32'h0CFE), 0, "R5 no load from short write");
        apply(1, 0, 4'd4, mkva(29'd2, 32'h0CF8), 32'h8000_1234, "R4 read of register");
        apply(1, 0, 4'd1, mkva(29'd2, 32'h0CFD), 0, "R5 no load from read");
        apply(1, 1, 4'd4, mkva(29'd2, 32'h0CF8), 32'h8ABC_DEF7, "R4 write of register");
        for (int p = 0; p < 4; p++)
            apply(1, 0, 4'd1, mkva(29'd2, 32'h0CFC + p), 0, "R6 enabled window");
        apply(1, 0, 4'd4, mkva(29'd2, 32'h0CFB), 0, "R8 below window");
        apply(1, 0, 4'd4, mkva(29'd2, 32'h0D00), 0, "R8 above window");
        apply(1, 1, 4'd4, mkva(29'd2, 32'h0CF8), 32'h7FFF_FFFF, "R4 disable");
        apply(1, 0, 4'd2, mkva(29'd2, 32'h0CFF), 0, "R7 disabled window");
        apply(1, 1, 4'd4, mkva(29'd2, 32'h0CF8), 32'hFFFF_FFFF, "R4 enable");
        // R1: mid-run reset clears the register
        @(negedge clk) begin rst_n = 1'b0; req_valid = 1'b0; end
        @(negedge clk) rst_n = 1'b1;
        shadow = 32'd0;
        apply(1, 0, 4'd4, mkva(29'd2, 32'h0CFC), 0, "R1 after mid-run reset");
        // Constrained random mix
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] prt;
            logic [28:0] code;
            logic [3:0]  sz;
            int sel;
            sel = $urandom_range(0, 9);
            case (sel)
                0, 1:    prt = 32'h0CF8;
                2, 3, 4: prt = 32'h0CFC + $urandom_range(0, 3);
                5:       prt = $urandom() | 32'h0001_0000;
                default: prt = {16'd0, 16'($urandom())};
            endcase
            code = ($urandom_range(0, 15) == 0) ? 29'($urandom()) : 29'd2;
            case ($urandom_range(0, 3))
                0: sz = 4'd1;
                1: sz = 4'd2;
                2: sz = 4'd8;
                default: sz = 4'd4;
            endcase
            apply($urandom_range(0, 7) != 0, $urandom_range(0, 1) == 1, sz,
                  mkva(code, prt), $urandom(), "R10 random mix");
        end
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule